// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns a deliberate two-button gesture into a system reset. It watches two active-low push-button inputs, which are already synchronized to `clk`. When both inputs stay low together for a selected hold interval, it emits one active-low reset pulse of fixed length. A select input picks one of two hold intervals. A configuration input can turn the longer setting into a near-immediate test setting.

The output models an open-drain pin. `rst_od_en` high means the pin is pulled low. When it is low the pin floats and an external pull-up takes it high. `rst_level_n` is the level the pin would show.

After power-on reset the block waits out a start-up window. If both buttons are found held at the end of that window, it fires a pulse straight away and does not demand the full hold interval. All intervals are given in microseconds and scaled by a cycles-per-microsecond parameter. A bench can therefore shrink every interval to a few cycles.

Top module: `pbr_longpress_rst`

## Requirements
- R1: Once both buttons are sampled low on N consecutive rising edges (N being the selected interval in cycles), `rst_od_en` is high after the Nth edge. It is not high any earlier.
- R2: With `tsel` = 0 the interval is HOLD_A_US × CYC_PER_US cycles, whatever the value of `zero_test_cfg`.
- R3: With `tsel` = 1 and `zero_test_cfg` = 0 the interval is HOLD_B_US × CYC_PER_US cycles.
- R4: With `tsel` = 1 and `zero_test_cfg` = 1 the interval is DETECT_US × CYC_PER_US cycles, which models the test setting.
- R5: Every pulse holds `rst_od_en` high for exactly PULSE_US × CYC_PER_US cycles. Releasing the buttons during a pulse does not shorten it.
- R6: If either button is sampled high before the interval completes, the count clears. The next press counts from zero. One button alone never produces a pulse.
- R7: After a pulse, both buttons must be sampled high at least once before a new hold can start. A press held through and past a pulse yields one pulse only.
- R8: A change on `tsel` while a hold is in progress clears the count. The hold then needs a full new interval, counted from the edge after the one that sees the change.
- R9: After `por_n` is released, `rst_od_en` stays low for STARTUP_US × CYC_PER_US edges. If both buttons are low on the last edge of that window, the pulse starts right after that edge. Otherwise the block enters normal hold detection.
- R10: During `por_n` low, `rst_od_en` is 0 and `rst_level_n` is 1. At all times `rst_level_n` is the inverse of `rst_od_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| btn_a_n | input | 1 | First button, active low, synchronized |
| btn_b_n | input | 1 | Second button, active low, synchronized |
| tsel | input | 1 | Hold interval select |
| zero_test_cfg | input | 1 | Makes `tsel` = 1 choose the short test interval |
| rst_od_en | output | 1 | Open-drain pull-down enable, 1 during the reset pulse |
| rst_level_n | output | 1 | Modelled pin level, 0 during the reset pulse |

## Verification
Two situations are hard to reach from the ports. The first is a `tsel` flip in the middle of a hold that is still in progress. The second is the start-up path, where the buttons are already pressed while `por_n` is low. For the first, the bench holds both buttons low for a few edges, flips `tsel` at a falling edge, and measures how many edges pass before the pulse. A stale count would make the pulse appear too early. For the second, the bench asserts `por_n` with the buttons in several patterns, releases it, and times the pulse against the start-up window. It also checks that a press held well past the pulse produces no second pulse.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    PB_BOOT     = 2'd0,
    PB_IDLE     = 2'd1,
    PB_PULSE    = 2'd2,
    PB_WAIT_REL = 2'd3
  } pbr_state_e;
endpackage

// File: rtl/pbr_span_cnt.sv
module pbr_span_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last_val,
  output logic         at_last
);
  logic [W-1:0] cnt;

  assign at_last = (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/pbr_interval_sel.sv
module pbr_interval_sel #(
  parameter int unsigned W     = 8,
  parameter int unsigned A_CYC = 8,
  parameter int unsigned B_CYC = 16,
  parameter int unsigned D_CYC = 2
) (
  input  logic         tsel,
  input  logic         zero_test,
  output logic [W-1:0] last_val
);
  always_comb begin
    if (!tsel)          last_val = W'(A_CYC - 1);
    else if (zero_test) last_val = W'(D_CYC - 1);
    else                last_val = W'(B_CYC - 1);
  end
endmodule

// File: rtl/pbr_longpress_rst.sv
module pbr_longpress_rst
  import pbr_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 10,
  parameter int unsigned HOLD_A_US  = 7_500_000,
  parameter int unsigned HOLD_B_US  = 12_500_000,
  parameter int unsigned DETECT_US  = 150,
  parameter int unsigned STARTUP_US = 300,
  parameter int unsigned PULSE_US   = 400_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_a_n,
  input  logic btn_b_n,
  input  logic tsel,
  input  logic zero_test_cfg,
  output logic rst_od_en,
  output logic rst_level_n
);
  localparam int unsigned HOLD_A_CYC  = HOLD_A_US  * CYC_PER_US;
  localparam int unsigned HOLD_B_CYC  = HOLD_B_US  * CYC_PER_US;
  localparam int unsigned DETECT_CYC  = DETECT_US  * CYC_PER_US;
  localparam int unsigned STARTUP_CYC = STARTUP_US * CYC_PER_US;
  localparam int unsigned PULSE_CYC   = PULSE_US   * CYC_PER_US;
  localparam int unsigned HOLD_MAX    = (HOLD_A_CYC > HOLD_B_CYC) ? HOLD_A_CYC : HOLD_B_CYC;
  localparam int unsigned PHASE_MAX   = (STARTUP_CYC > PULSE_CYC) ? STARTUP_CYC : PULSE_CYC;
  localparam int unsigned HW = $clog2(HOLD_MAX + 1);
  localparam int unsigned PW = $clog2(PHASE_MAX + 1);

  pbr_state_e st_q, st_nxt;
  logic       tsel_q;
  logic       both_low, both_high, tsel_chg;
  logic       hold_last, hold_clr, hold_done;
  logic       phase_last, phase_clr;
  logic [HW-1:0] hold_limit;
  logic [PW-1:0] phase_limit;

  assign both_low  = ~btn_a_n & ~btn_b_n;
  assign both_high =  btn_a_n &  btn_b_n;
  assign tsel_chg  = tsel ^ tsel_q;

  pbr_interval_sel #(
    .W(HW), .A_CYC(HOLD_A_CYC), .B_CYC(HOLD_B_CYC), .D_CYC(DETECT_CYC)
  ) u_isel (
    .tsel      (tsel),
    .zero_test (zero_test_cfg),
    .last_val  (hold_limit)
  );

  // hold timer: runs only in IDLE while both buttons stay low and tsel is steady
  assign hold_clr  = (st_q != PB_IDLE) | ~both_low | tsel_chg;
  assign hold_done = (st_q == PB_IDLE) & both_low & ~tsel_chg & hold_last;

  pbr_span_cnt #(.W(HW)) u_hold (
    .clk      (clk),
    .rst_n    (por_n),
    .clr      (hold_clr),
    .en       (1'b1),
    .last_val (hold_limit),
    .at_last  (hold_last)
  );

  // phase timer: shared by the start-up window and the reset pulse
  assign phase_limit = (st_q == PB_BOOT) ? PW'(STARTUP_CYC - 1) : PW'(PULSE_CYC - 1);
  assign phase_clr   = (st_nxt != st_q);

  pbr_span_cnt #(.W(PW)) u_phase (
    .clk      (clk),
    .rst_n    (por_n),
    .clr      (phase_clr),
    .en       (1'b1),
    .last_val (phase_limit),
    .at_last  (phase_last)
  );

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      PB_BOOT:     if (phase_last) st_nxt = both_low ? PB_PULSE : PB_IDLE;
      PB_IDLE:     if (hold_done)  st_nxt = PB_PULSE;
      PB_PULSE:    if (phase_last) st_nxt = PB_WAIT_REL;
      PB_WAIT_REL: if (both_high)  st_nxt = PB_IDLE;
      default:                     st_nxt = PB_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q   <= PB_BOOT;
      tsel_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      tsel_q <= tsel;
    end
  end

  assign rst_od_en   = (st_q == PB_PULSE);
  assign rst_level_n = ~rst_od_en;
endmodule

// File: rtl/pbr_longpress_chk.sv
module pbr_longpress_chk #(
  parameter int unsigned PULSE_CYC   = 4,
  parameter int unsigned STARTUP_CYC = 4
) (
  input logic clk,
  input logic por_n,
  input logic btn_a_n,
  input logic btn_b_n,
  input logic rst_od_en
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 2);
  localparam int unsigned SW = $clog2(STARTUP_CYC + 2);

  logic [PW-1:0] plen;
  logic [SW-1:0] since_rst;
  logic          rel_ok;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      plen      <= '0;
      since_rst <= '0;
      rel_ok    <= 1'b1;
    end else begin
      if (!rst_od_en)                   plen <= '0;
      else if (plen != PW'(PULSE_CYC + 1)) plen <= plen + PW'(1);
      if (since_rst < SW'(STARTUP_CYC)) since_rst <= since_rst + SW'(1);
      if (rst_od_en)                    rel_ok <= 1'b0;
      else if (btn_a_n && btn_b_n)      rel_ok <= 1'b1;
    end
  end

  // R1
  rise_needs_press_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_od_en) |-> $past(!btn_a_n && !btn_b_n));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_od_en) |-> (plen == PW'(PULSE_CYC)));

  // R5
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_od_en |-> (plen < PW'(PULSE_CYC)));

  // R7
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_od_en) |-> rel_ok);

  // R9
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (since_rst < SW'(STARTUP_CYC)) |-> !rst_od_en);
endmodule

bind pbr_longpress_rst pbr_longpress_chk #(
  .PULSE_CYC   (PULSE_CYC),
  .STARTUP_CYC (STARTUP_CYC)
) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .btn_a_n   (btn_a_n),
  .btn_b_n   (btn_b_n),
  .rst_od_en (rst_od_en)
);

// File: tb/pbr_longpress_rst_bench.sv
`timescale 1ns/1ps
module pbr_longpress_rst_bench;
  localparam int CPU = 1;
  localparam int HA = 12, HB = 20, DT = 3, SU = 5, PL = 6;
  localparam int TA = HA * CPU, TB = HB * CPU, TD = DT * CPU;
  localparam int TS = SU * CPU, TP = PL * CPU;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic btn_a_n = 1'b1, btn_b_n = 1'b1;
  logic tsel = 1'b0, zero_test_cfg = 1'b0;
  logic rst_od_en, rst_level_n;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  pbr_longpress_rst #(
    .CYC_PER_US(CPU), .HOLD_A_US(HA), .HOLD_B_US(HB),
    .DETECT_US(DT), .STARTUP_US(SU), .PULSE_US(PL)
  ) u_pbr_longpress_rst (
    .clk(clk), .por_n(por_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .tsel(tsel), .zero_test_cfg(zero_test_cfg),
    .rst_od_en(rst_od_en), .rst_level_n(rst_level_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // called at a falling edge with buttons already set; releases both at edge L
  task automatic watch(input int L, input int total, input int exp_first,
                       input int exp_len, input string req);
    int first = 0, len = 0, lvl_bad = 0;
    for (int i = 1; i <= total; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == L) begin btn_a_n = 1'b1; btn_b_n = 1'b1; end
      if (rst_od_en) begin
        if (first == 0) first = i;
        len++;
      end
      if (rst_level_n !== ~rst_od_en) lvl_bad++;
    end
    check(first == exp_first, {req, " pulse start"}, first, exp_first);
    check(len == exp_len, {req, " pulse length (R5)"}, len, exp_len);
    check(lvl_bad == 0, {req, " pin level R10"}, lvl_bad, 0);
  endtask

  task automatic press_watch(input logic [1:0] mask, input int L, input int total,
                             input int exp_first, input int exp_len, input string req);
    btn_a_n = ~mask[0];
    btn_b_n = ~mask[1];
    watch(L, total, exp_first, exp_len, req);
  endtask

  task automatic boot_watch(input logic [1:0] mask, input int L, input int total,
                            input int exp_first, input int exp_len, input string req);
    @(negedge clk);
    por_n = 1'b0;
    btn_a_n = ~mask[0];
    btn_b_n = ~mask[1];
    repeat (3) @(negedge clk);
    check(rst_od_en == 1'b0, "R10 reset state od_en", rst_od_en, 0);
    check(rst_level_n == 1'b1, "R10 reset state level", rst_level_n, 1);
    por_n = 1'b1;
    watch(L, total, exp_first, exp_len, req);
  endtask

  task automatic sweep(input int T, input string req);
    for (int L = 1; L <= T + 2; L++) begin
      int total = ((L > T) ? L : T) + TP + 3;
      press_watch(2'b11, L, total, (L >= T) ? T : 0, (L >= T) ? TP : 0, req);
    end
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    // R9: start-up with both buttons held, released during the pulse
    boot_watch(2'b11, TS + 2, TS + TP + 4, TS, TP, "R9 boot pressed");
    // R9: released before the window ends, no pulse
    boot_watch(2'b11, TS - 2, TS + TP + 4, 0, 0, "R9 boot early release");
    // R9: one button at start-up
    boot_watch(2'b01, TS + 2, TS + TP + 4, 0, 0, "R9 boot one button");
    // R7: held from start-up far past the pulse, one pulse only
    boot_watch(2'b11, TS + TP + TA + 5, TS + TP + TA + 8, TS, TP, "R7 boot held");
    // R9: start-up with no press, then normal hold
    boot_watch(2'b00, 1, TS + 4, 0, 0, "R9 boot idle");

    // R2: tsel low, both values of the test config
    tsel = 1'b0; zero_test_cfg = 1'b0;
    sweep(TA, "R2 R1 tsel0 cfg0");
    zero_test_cfg = 1'b1;
    sweep(TA, "R2 R1 tsel0 cfg1");
    // R3
    tsel = 1'b1; zero_test_cfg = 1'b0;
    sweep(TB, "R3 R1 tsel1 cfg0");
    // R4
    zero_test_cfg = 1'b1;
    sweep(TD, "R4 R1 tsel1 cfg1");

    tsel = 1'b0; zero_test_cfg = 1'b0;
    // R6: single buttons held long
    press_watch(2'b01, TA + 5, TA + 8, 0, 0, "R6 only A");
    press_watch(2'b10, TA + 5, TA + 8, 0, 0, "R6 only B");
    // R6: interrupted press then a full press
    press_watch(2'b11, TA - 1, TA - 1, 0, 0, "R6 short press");
    @(negedge clk);
    press_watch(2'b11, TA, TA + TP + 3, TA, TP, "R6 fresh press");
    // R6: staggered, counting starts when the second button goes low
    btn_a_n = 1'b0;
    repeat (4) @(negedge clk);
    press_watch(2'b11, TA, TA + TP + 3, TA, TP, "R6 staggered");
    // R7: held through the pulse after a normal hold
    press_watch(2'b11, TA + TP + TA + 4, TA + TP + TA + 7, TA, TP, "R7 held through");

    // R8: tsel change mid-hold restarts the count
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    repeat (5) @(negedge clk);
    tsel = 1'b1;
    press_watch(2'b11, TB + 2, TB + TP + 4, TB + 1, TP, "R8 tsel flip");
    tsel = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule